// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides the input clock of a frequency synthesizer's feedback path by a programmable ratio N. It models a dual-modulus prescaler that divides by 33 or by 32. A 5-bit swallow counter selects the modulus, and a main counter counts prescaler groups. The swallow counter holds the modulus at 33 for the first S groups of each period. The remaining M − S groups run at 32, so one period lasts N = 32·M + S input cycles. At the end of each period the block emits a one-cycle pulse that a phase detector compares against the reference.

The divider word holds the swallow value in its low bits and the main value above them. The width-select input chooses an 11-bit or a 13-bit main field. Both counters reload from the word only at the edge that closes a period, so a new ratio never cuts a period short. The modulus-control output is also brought out, so the prescaler's choice for every group can be observed.

Top module: `pksw_divider`

## Requirements
- R1: Once running, `fb_pulse_o` is high for exactly one cycle in every N = 32·M + S rising edges of `clk_i`.
- R2: S is `div_word_i[4:0]`. M is `div_word_i[15:5]` when `wide_i` is 0 and `div_word_i[17:5]` when `wide_i` is 1. When `wide_i` is 0, bits 17:16 have no effect on the ratio.
- R3: `mod_hi_o` (1 = divide by 33) is high for the first 33·S cycles of each period and low for the rest of it. It never falls in the cycle where `fb_pulse_o` is high, and once low it stays low until the next period starts.
- R4: `fb_pulse_o` is never high in two consecutive cycles.
- R5: `div_word_i` and `wide_i` are sampled only at the edge that ends a period. Changes between two such edges do not alter the period in progress.
- R6: While `rst_ni` is low, and until the first period starts, both outputs are low. The first period starts on the third rising edge after `rst_ni` rises, and the first pulse follows N edges later.
- R7: A short-mode word with M = 379 and S = 28 gives a spacing of 12156 cycles. A long-mode word with M = 1650 and S = 0 gives a spacing of 52800 cycles.
- R8: In long mode a main value above 2047 gives ratios beyond 65535; M = 2049 with S = 3 gives 65571 cycles. Correct operation requires M ≥ S and M ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_word_i | input | 18 | Latched divider word: swallow value low, main value above |
| wide_i | input | 1 | 0 = 11-bit main field, 1 = 13-bit main field |
| mod_hi_o | output | 1 | Prescaler modulus control, 1 = divide by 33 |
| fb_pulse_o | output | 1 | One-cycle pulse per N input cycles |

## Verification
The bench builds the block with its default parameters: a 5-bit swallow field with a 32/33 modulus, and main fields of 11 and 13 bits. With these values the two encoded ratios of 12156 and 52800 fit in the cycle budget, as does a long-mode ratio just above 65535. The largest long-mode ratios near 262143 are out of reach. The bench changes the word in the middle of a period, including junk in the high bits and a mode flip, to show that only the boundary sample counts.

// File: rtl/pksw_pkg.sv
package pksw_pkg;
  localparam int unsigned SWALLOW_W_DEF = 5;
  localparam int unsigned MAIN_SHORT_DEF = 11;
  localparam int unsigned MAIN_LONG_DEF = 13;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } main_mode_e;
endpackage

// File: rtl/pksw_rst_sync.sv
module pksw_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/pksw_prescaler.sv
module pksw_prescaler #(
  parameter int unsigned SW_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic mod_hi_i,
  output logic tick_o
);
  localparam int unsigned PC_W = SW_W + 1;
  localparam logic [PC_W-1:0] TC_LO = {1'b0, {SW_W{1'b1}}};
  localparam logic [PC_W-1:0] TC_HI = {1'b1, {SW_W{1'b0}}};
  localparam logic [PC_W-1:0] ONE   = {{(PC_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == (mod_hi_i ? TC_HI : TC_LO));

  always_comb begin
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pksw_swallow_ctr.sv
module pksw_swallow_ctr #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         step_i,
  output logic         busy_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  assign busy_o = |cnt_q;
  assign en     = load_i | (step_i & busy_o);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (en)  cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pksw_main_ctr.sv
module pksw_main_ctr #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         step_i,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  assign last_o = (cnt_q == ONE);
  assign en     = load_i | step_i;

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (en)  cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pksw_divider.sv
module pksw_divider
  import pksw_pkg::*;
#(
  parameter int unsigned SW_W         = SWALLOW_W_DEF,
  parameter int unsigned MAIN_W_SHORT = MAIN_SHORT_DEF,
  parameter int unsigned MAIN_W_LONG  = MAIN_LONG_DEF,
  localparam int unsigned WORD_W      = SW_W + MAIN_W_LONG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] div_word_i,
  input  logic              wide_i,
  output logic              mod_hi_o,
  output logic              fb_pulse_o
);
  localparam int unsigned PAD_W = MAIN_W_LONG - MAIN_W_SHORT;

  logic                   rst_n_int;
  logic                   load_q, load_d;
  logic                   pulse_q, pulse_d;
  logic                   tick, last, busy, restart, step;
  logic [SW_W-1:0]        s_val;
  logic [MAIN_W_LONG-1:0] m_val, m_short, m_long;
  main_mode_e             mode;

  pksw_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  // field selection from the latched word
  assign mode    = main_mode_e'(wide_i);
  assign s_val   = div_word_i[SW_W-1:0];
  assign m_long  = div_word_i[WORD_W-1:SW_W];
  assign m_short = {{PAD_W{1'b0}}, div_word_i[SW_W+MAIN_W_SHORT-1:SW_W]};
  assign m_val   = (mode == MODE_LONG) ? m_long : m_short;

  assign step    = tick & ~load_q;
  assign restart = load_q | (step & last);

  pksw_prescaler #(.SW_W(SW_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .clr_i    (load_q),
    .mod_hi_i (busy),
    .tick_o   (tick)
  );

  pksw_swallow_ctr #(.W(SW_W)) u_swallow (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .load_i (restart),
    .val_i  (s_val),
    .step_i (step),
    .busy_o (busy)
  );

  pksw_main_ctr #(.W(MAIN_W_LONG)) u_main (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .load_i (restart),
    .val_i  (m_val),
    .step_i (step),
    .last_o (last)
  );

  always_comb begin
    load_d  = 1'b0;
    pulse_d = step & last;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      load_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      load_q  <= load_d;
      pulse_q <= pulse_d;
    end
  end

  assign mod_hi_o   = busy;
  assign fb_pulse_o = pulse_q;
endmodule

// File: rtl/pksw_divider_chk.sv
module pksw_divider_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fb_pulse_i,
  input logic mod_hi_i,
  input logic load_q_i
);
  // R4: pulse lasts one cycle
  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_i |=> !fb_pulse_i);

  // R3: once the modulus drops to 32 it stays there until a new period starts
  p_swallow_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_hi_i && !fb_pulse_i && !load_q_i) |=> (!mod_hi_i || fb_pulse_i));

  // R3: modulus falls inside a period, never at its boundary
  p_fell_midperiod_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_hi_i) |-> !fb_pulse_i);

  // R6: outputs quiet before the first period starts
  p_quiet_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q_i |-> (!fb_pulse_i && !mod_hi_i));
endmodule

bind pksw_divider pksw_divider_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fb_pulse_i (fb_pulse_o),
  .mod_hi_i   (mod_hi_o),
  .load_q_i   (load_q)
);

// File: tb/pksw_divider_tb.sv
module pksw_divider_tb;
  logic        clk;
  logic        rst_n;
  logic [17:0] word;
  logic        wide;
  logic        mod_hi, pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int    sync_cnt = 0;
  bit    loaded   = 0;
  int    rem = 0, n_cur = 0, s_cur = 0;
  bit    exp_pulse = 0, exp_mod = 0, prev_exp_pulse = 0;
  int    pulses = 0;
  string tag = "R6";

  pksw_divider u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_word_i (word),
    .wide_i     (wide),
    .mod_hi_o   (mod_hi),
    .fb_pulse_o (pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [17:0] mk(int m, int s, int hi2);
    mk = 18'((hi2 << 16) | (m << 5) | s);
  endfunction

  task automatic load_word();
    int s, m;
    s = int'(word[4:0]);
    m = wide ? int'(word[17:5]) : int'(word[15:5]);
    n_cur = 32 * m + s;
    s_cur = s;
    rem   = n_cur;
  endtask

  task automatic step();
    @(posedge clk);
    prev_exp_pulse = exp_pulse;
    if (!rst_n) begin
      sync_cnt = 0; loaded = 0; exp_pulse = 0;
    end else if (sync_cnt < 2) begin
      sync_cnt++; exp_pulse = 0;
    end else if (!loaded) begin
      loaded = 1; load_word(); exp_pulse = 0;
    end else begin
      rem--;
      if (rem == 0) begin
        exp_pulse = 1; pulses++; load_word();
      end else exp_pulse = 0;
    end
    exp_mod = loaded && ((n_cur - rem) < 33 * s_cur);
    @(negedge clk);
    checks++;
    if (pulse !== exp_pulse) begin
      fails++;
      $display("FAIL %s pulse: actual %b expected %b (period %0d)",
               prev_exp_pulse ? "R4" : (loaded ? tag : "R6"), pulse, exp_pulse, n_cur);
    end
    checks++;
    if (mod_hi !== exp_mod) begin
      fails++;
      $display("FAIL %s modulus: actual %b expected %b (period %0d)",
               loaded ? "R3" : "R6", mod_hi, exp_mod, n_cur);
    end
  endtask

  task automatic wait_pulses(int k);
    int target;
    target = pulses + k;
    while (pulses < target) step();
  endtask

  initial begin
    rst_n = 1'b0;
    wide  = 1'b0;
    word  = mk(32, 5, 0);                 // R1: N = 1029
    @(negedge clk);
    repeat (5) step();                    // R6: quiet in reset
    rst_n = 1'b1;
    tag = "R6";
    wait_pulses(1);                       // R6: first pulse at edge 3 + N
    tag = "R1";
    word = mk(40, 31, 0);                 // R1: N = 1311 for period three
    wait_pulses(1);
    tag = "R5";
    repeat (300) step();
    word = mk(32, 0, 1); wide = 1'b1;     // R5: junk mid-period
    repeat (300) step();
    word = mk(33, 1, 3); wide = 1'b0;     // R2: high bits set, short mode
    wait_pulses(1);
    tag = "R2";
    word = mk(379, 28, 0);                // R7: N = 12156
    wait_pulses(1);
    tag = "R7";
    word = mk(2049, 3, 0); wide = 1'b1;   // R8: N = 65571
    wait_pulses(1);
    tag = "R8";
    word = mk(1650, 0, 0);                // R7: N = 52800 long mode
    wait_pulses(1);
    tag = "R7";
    word = mk(32, 0, 0); wide = 1'b0;     // R1: N = 1024, S = 0
    wait_pulses(1);
    tag = "R1";
    wait_pulses(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual cycles %0d expected fewer than %0d", 195000, 195000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule